// File: doc/BRIEF.md
# Page-Granular Cache Tag Classifier

This block is the lookup stage of a cache that keeps one tag entry per large page (4 KB) instead of one per line (128 bytes). A page entry can be resident while some of its 32 lines are still missing. Each entry therefore holds five things: a valid bit, the page tag, a 32-bit presence vector with one bit per line, a flag saying whether the page currently sits in the fast page buffer, and the buffer slot it occupies. The store is four-way set associative, with 16 sets.

Every request carries a line address and a read/write flag. The block sorts the request into one of six outcomes. One cycle later it reports the outcome, the way concerned, the buffer slot and the set of follow-up actions that the surrounding controller must carry out. Reads and writes are sorted the same way, because writes allocate on a miss. The write flag is only carried through to the response, so that the controller can send the write on to the next level.

A separate update port lets the controller change the store:
- fill a line of a resident page;
- install a new page in a way;
- mark a page as buffered in a given slot;
- remove the buffered mark from a page.

The block keeps a least-recently-used order per set, and uses it to name the victim way when every way of a set is occupied.

Top module: `pgtag_top`

## Requirements
- R1: After reset every entry is invalid, rsp_valid is 0, and the recency order of each set has way 0 as least recently used and way 3 as most recently used. A first lookup to any address therefore gives outcome 1 on way 0.
- R2: The line address splits into three fields: line-in-page = bits [4:0], set = bits [8:5], tag = bits [24:9]. A request accepted with req_valid at a clock edge is answered with rsp_valid exactly at the next edge, and only then. The answer is computed from the store as it was before any update applied at that same edge.
- R3: If no valid way holds the tag and at least one way is invalid, the outcome is 1 and the way is the lowest-numbered invalid way. The action is 4'b1101, where action bit 3 = allocate page, bit 2 = allocate buffer slot, bit 1 = copy page into buffer, and bit 0 = fetch line. The slot is 0.
- R4: If no valid way holds the tag and all four ways are valid, the outcome is 2, the way is the least recently used way of the set, the action is 4'b1101 and the slot is 0.
- R5: If the tag matches, the line's presence bit is 0 and the page is not buffered, the outcome is 3, the action is 4'b0111 and the slot is 0.
- R6: If the tag matches, the presence bit is 1 and the page is not buffered (a delayed hit), the outcome is 4, the action is 4'b0110 and the slot is 0.
- R7: If the tag matches, the presence bit is 0 and the page is buffered, the outcome is 5, the action is 4'b0001 and the slot is the entry's slot.
- R8: If the tag matches and both the presence bit and the buffered flag are 1 (a fast hit), the outcome is 6, the action is 4'b0000 and the slot is the entry's slot.
- R9: The update port applies one operation at a clock edge; upd_op selects it.
  - 0 = fill: set the presence bit of upd_line.
  - 1 = install: the entry becomes valid with upd_tag, only upd_line present, buffered, in slot upd_slot.
  - 2 = buffer: set the buffered flag and take upd_slot as the slot.
  - 3 = unbuffer: clear the buffered flag.
- R10: A lookup whose tag matches makes that way the most recently used in its set. An install does the same to the installed way. When both happen in one cycle to the same set, the install counts as the more recent.
- R11: rsp_write repeats the write flag of the answered request, and a write gets the same outcome, way, slot and action as a read would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_line_addr | input | 25 | Line address: tag, set and line-in-page |
| req_write | input | 1 | Request is a write |
| upd_valid | input | 1 | Update strobe |
| upd_op | input | 2 | Update operation: fill, install, buffer or unbuffer |
| upd_set | input | 4 | Set to update |
| upd_way | input | 2 | Way to update |
| upd_tag | input | 16 | Page tag for install |
| upd_line | input | 5 | Line for fill or install |
| upd_slot | input | 4 | Buffer slot for install or buffer |
| rsp_valid | output | 1 | Response strobe |
| rsp_outcome | output | 3 | Outcome code 1 to 6 |
| rsp_way | output | 2 | Matching, free or victim way |
| rsp_slot | output | 4 | Buffer slot of a buffered matching page, else 0 |
| rsp_action | output | 4 | Allocate page, allocate slot, copy page, fetch line |
| rsp_write | output | 1 | Write flag of the answered request |

## Verification
The victim outcome is the hardest to reach. It only occurs once all four ways of one set hold distinct valid tags, and its way then depends on the whole history of tag-matching lookups and installs in that set. The stimulus fills one set through the update port, touches ways in a chosen order with hitting lookups, and then asks for an absent tag. A lookup issued in the same cycle as a fill of the same line checks that the answer reflects the old state. A long random phase then mixes requests and updates over two sets and six tags, never installing a tag twice in one set. Every response is compared with a behavioural model that keeps the recency order as a list.

// File: rtl/pgtag_pkg.sv
package pgtag_pkg;
    parameter int ADDR_W     = 32;
    parameter int PAGE_BYTES = 4096;
    parameter int LINE_BYTES = 128;
    parameter int SETS       = 16;
    parameter int WAYS       = 4;
    parameter int SLOTS      = 16;

    localparam int LINE_OFF_W = $clog2(LINE_BYTES);
    localparam int LINES      = PAGE_BYTES / LINE_BYTES;
    localparam int LINE_W     = $clog2(LINES);
    localparam int SET_W      = $clog2(SETS);
    localparam int WAY_W      = $clog2(WAYS);
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int TAG_W      = ADDR_W - LINE_OFF_W - LINE_W - SET_W;
    localparam int LADDR_W    = ADDR_W - LINE_OFF_W;
    localparam int ACT_W      = 4;

    // action bits
    localparam int ACT_ALLOC_PAGE = 3;
    localparam int ACT_ALLOC_SLOT = 2;
    localparam int ACT_COPY_PAGE  = 1;
    localparam int ACT_FETCH_LINE = 0;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [LINES-1:0]  pres;
        logic              buffered;
        logic [SLOT_W-1:0] slot;
    } entry_t;

    typedef entry_t [WAYS-1:0]                  set_ent_t;
    typedef logic   [WAYS-1:0][WAY_W-1:0]       age_row_t;

    typedef enum logic [2:0] {
        OC_NONE       = 3'd0,
        OC_PAGE_FREE  = 3'd1,
        OC_PAGE_EVICT = 3'd2,
        OC_LINE_NOBUF = 3'd3,
        OC_DELAYED    = 3'd4,
        OC_LINE_BUF   = 3'd5,
        OC_FAST       = 3'd6
    } outcome_e;

    typedef enum logic [1:0] {
        UP_FILL     = 2'd0,
        UP_INSTALL  = 2'd1,
        UP_BUFFER   = 2'd2,
        UP_UNBUFFER = 2'd3
    } upd_op_e;

    typedef struct packed {
        logic              valid;
        outcome_e          outcome;
        logic [WAY_W-1:0]  way;
        logic [SLOT_W-1:0] slot;
        logic [ACT_W-1:0]  action;
        logic              write;
    } rsp_t;
endpackage

// File: rtl/pgtag_store.sv
module pgtag_store
    import pgtag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  upd_op_e           upd_op,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [SLOT_W-1:0] upd_slot,
    input  logic [SET_W-1:0]  rd_set,
    output set_ent_t          rd_ent
);
    set_ent_t [SETS-1:0] mem_d, mem_q;
    localparam logic [LINES-1:0] ONE_LINE = {{(LINES-1){1'b0}}, 1'b1};

    always_comb begin
        mem_d = mem_q;
        if (upd_valid) begin
            case (upd_op)
                UP_FILL:     mem_d[upd_set][upd_way].pres[upd_line] = 1'b1;
                UP_INSTALL: begin
                    mem_d[upd_set][upd_way].valid    = 1'b1;
                    mem_d[upd_set][upd_way].tag      = upd_tag;
                    mem_d[upd_set][upd_way].pres     = ONE_LINE << upd_line;
                    mem_d[upd_set][upd_way].buffered = 1'b1;
                    mem_d[upd_set][upd_way].slot     = upd_slot;
                end
                UP_BUFFER: begin
                    mem_d[upd_set][upd_way].buffered = 1'b1;
                    mem_d[upd_set][upd_way].slot     = upd_slot;
                end
                default:     mem_d[upd_set][upd_way].buffered = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_ent = mem_q[rd_set];

    // R9: an installed way reads back valid with only the named line present
    always_ff @(posedge clk) begin
        if (rst_n && $past(rst_n) && $past(upd_valid) && $past(upd_op) == UP_INSTALL) begin
            assert_install_single_R9: assert (mem_q[$past(upd_set)][$past(upd_way)].valid &&
                    $countones(mem_q[$past(upd_set)][$past(upd_way)].pres) == 1)
                else $error("install did not leave a single present line");
        end
    end
endmodule

// File: rtl/pgtag_lru.sv
module pgtag_lru
    import pgtag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             look_touch,
    input  logic [SET_W-1:0] look_set,
    input  logic [WAY_W-1:0] look_way,
    input  logic             inst_touch,
    input  logic [SET_W-1:0] inst_set,
    input  logic [WAY_W-1:0] inst_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim
);
    // age 0 = most recent, WAYS-1 = least recent
    age_row_t [SETS-1:0] age_d, age_q;

    function automatic age_row_t touch(input age_row_t r, input logic [WAY_W-1:0] w);
        age_row_t o;
        o = r;
        for (int i = 0; i < WAYS; i++) begin
            if (r[i] < r[w]) o[i] = r[i] + 1'b1;
        end
        o[w] = '0;
        return o;
    endfunction

    always_comb begin
        age_d = age_q;
        if (look_touch) age_d[look_set] = touch(age_d[look_set], look_way);
        if (inst_touch) age_d[inst_set] = touch(age_d[inst_set], inst_way);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
        end else begin
            age_q <= age_d;
        end
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[rd_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end

    logic perm_ok;
    always_comb begin
        logic [WAYS-1:0] seen;
        perm_ok = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) seen[age_q[s][w]] = 1'b1;
            if (!(&seen)) perm_ok = 1'b0;
        end
    end

    // R10: the ages of every set always form a permutation
    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_lru_perm_R10: assert (perm_ok) else $error("recency ages are not a permutation");
        end
    end
endmodule

// File: rtl/pgtag_classify.sv
module pgtag_classify
    import pgtag_pkg::*;
(
    input  set_ent_t          ent,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [LINE_W-1:0] req_line,
    input  logic [WAY_W-1:0]  victim,
    output outcome_e          outcome,
    output logic [WAY_W-1:0]  way,
    output logic [SLOT_W-1:0] slot,
    output logic [ACT_W-1:0]  action,
    output logic              tag_hit,
    output logic [WAYS-1:0]   match
);
    logic [WAYS-1:0]  free;
    logic [WAY_W-1:0] hit_way, free_way;
    logic             present, buffered;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match[w] = ent[w].valid && (ent[w].tag == req_tag);
            free[w]  = !ent[w].valid;
        end
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way  = WAY_W'(w);
            if (free[w])  free_way = WAY_W'(w);
        end
        tag_hit  = |match;
        present  = ent[hit_way].pres[req_line];
        buffered = ent[hit_way].buffered;

        outcome = OC_NONE;
        way     = hit_way;
        slot    = '0;
        action  = '0;
        if (tag_hit) begin
            case ({present, buffered})
                2'b00: begin
                    outcome = OC_LINE_NOBUF;
                    action[ACT_ALLOC_SLOT] = 1'b1;
                    action[ACT_COPY_PAGE]  = 1'b1;
                    action[ACT_FETCH_LINE] = 1'b1;
                end
                2'b10: begin
                    outcome = OC_DELAYED;
                    action[ACT_ALLOC_SLOT] = 1'b1;
                    action[ACT_COPY_PAGE]  = 1'b1;
                end
                2'b01: begin
                    outcome = OC_LINE_BUF;
                    action[ACT_FETCH_LINE] = 1'b1;
                    slot = ent[hit_way].slot;
                end
                default: begin
                    outcome = OC_FAST;
                    slot = ent[hit_way].slot;
                end
            endcase
        end else begin
            outcome = (|free) ? OC_PAGE_FREE : OC_PAGE_EVICT;
            way     = (|free) ? free_way : victim;
            action[ACT_ALLOC_PAGE] = 1'b1;
            action[ACT_ALLOC_SLOT] = 1'b1;
            action[ACT_FETCH_LINE] = 1'b1;
        end
    end
endmodule

// File: rtl/pgtag_top.sv
module pgtag_top
    import pgtag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_line_addr,
    input  logic               req_write,
    input  logic               upd_valid,
    input  logic [1:0]         upd_op,
    input  logic [SET_W-1:0]   upd_set,
    input  logic [WAY_W-1:0]   upd_way,
    input  logic [TAG_W-1:0]   upd_tag,
    input  logic [LINE_W-1:0]  upd_line,
    input  logic [SLOT_W-1:0]  upd_slot,
    output logic               rsp_valid,
    output logic [2:0]         rsp_outcome,
    output logic [WAY_W-1:0]   rsp_way,
    output logic [SLOT_W-1:0]  rsp_slot,
    output logic [ACT_W-1:0]   rsp_action,
    output logic               rsp_write
);
    logic [LINE_W-1:0] req_line;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    assign req_line = req_line_addr[LINE_W-1:0];
    assign req_set  = req_line_addr[LINE_W +: SET_W];
    assign req_tag  = req_line_addr[LADDR_W-1 -: TAG_W];

    upd_op_e           op;
    set_ent_t          rd_ent;
    logic [WAY_W-1:0]  victim;
    outcome_e          cls_outcome;
    logic [WAY_W-1:0]  cls_way;
    logic [SLOT_W-1:0] cls_slot;
    logic [ACT_W-1:0]  cls_action;
    logic              cls_tag_hit;
    logic [WAYS-1:0]   cls_match;
    assign op = upd_op_e'(upd_op);

    pgtag_store u_store (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_op(op), .upd_set(upd_set), .upd_way(upd_way),
        .upd_tag(upd_tag), .upd_line(upd_line), .upd_slot(upd_slot),
        .rd_set(req_set), .rd_ent(rd_ent)
    );

    pgtag_lru u_lru (
        .clk(clk), .rst_n(rst_n),
        .look_touch(req_valid && cls_tag_hit), .look_set(req_set), .look_way(cls_way),
        .inst_touch(upd_valid && op == UP_INSTALL), .inst_set(upd_set), .inst_way(upd_way),
        .rd_set(req_set), .victim(victim)
    );

    pgtag_classify u_cls (
        .ent(rd_ent), .req_tag(req_tag), .req_line(req_line), .victim(victim),
        .outcome(cls_outcome), .way(cls_way), .slot(cls_slot), .action(cls_action),
        .tag_hit(cls_tag_hit), .match(cls_match)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid   = 1'b1;
            rsp_d.outcome = cls_outcome;
            rsp_d.way     = cls_way;
            rsp_d.slot    = cls_slot;
            rsp_d.action  = cls_action;
            rsp_d.write   = req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_outcome = rsp_q.outcome;
    assign rsp_way     = rsp_q.way;
    assign rsp_slot    = rsp_q.slot;
    assign rsp_action  = rsp_q.action;
    assign rsp_write   = rsp_q.write;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(cls_match));

    always_ff @(posedge clk) begin
        if (rst_n && req_valid) begin
            if (cls_outcome == OC_PAGE_FREE) begin
                assert_free_way_R3: assert (!rd_ent[cls_way].valid)
                    else $error("free-way miss names an occupied way");
            end
            if (cls_outcome == OC_PAGE_EVICT) begin
                for (int w = 0; w < WAYS; w++) begin
                    assert_evict_full_R4: assert (rd_ent[w].valid)
                        else $error("victim chosen while a way is free");
                end
            end
        end
    end
endmodule

// File: tb/pgtag_top_test.sv
`timescale 1ns/1ps
module pgtag_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [24:0] req_line_addr = '0;
    logic        req_write = 1'b0;
    logic        upd_valid = 1'b0;
    logic [1:0]  upd_op = '0;
    logic [3:0]  upd_set = '0;
    logic [1:0]  upd_way = '0;
    logic [15:0] upd_tag = '0;
    logic [4:0]  upd_line = '0;
    logic [3:0]  upd_slot = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_outcome;
    logic [1:0]  rsp_way;
    logic [3:0]  rsp_slot;
    logic [3:0]  rsp_action;
    logic        rsp_write;

    pgtag_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line_addr(req_line_addr),
        .req_write(req_write), .upd_valid(upd_valid), .upd_op(upd_op), .upd_set(upd_set),
        .upd_way(upd_way), .upd_tag(upd_tag), .upd_line(upd_line), .upd_slot(upd_slot),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_way(rsp_way),
        .rsp_slot(rsp_slot), .rsp_action(rsp_action), .rsp_write(rsp_write)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model
    bit m_valid [16][4];
    int m_tag   [16][4];
    bit m_pres  [16][4][32];
    bit m_buf   [16][4];
    int m_slot  [16][4];
    int m_ord   [16][4];   // recency list, most recent first

    task automatic model_reset();
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_buf[s][w] = 0; m_slot[s][w] = 0;
                for (int l = 0; l < 32; l++) m_pres[s][w][l] = 0;
                m_ord[s][w] = 3 - w;
            end
        end
    endtask

    task automatic model_touch(input int s, input int w);
        int k;
        k = 0;
        for (int i = 0; i < 4; i++) if (m_ord[s][i] == w) k = i;
        for (int i = k; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
        m_ord[s][0] = w;
    endtask

    function automatic logic [24:0] mkaddr(input int t, input int s, input int l);
        logic [15:0] tt;
        logic [3:0]  ss;
        logic [4:0]  ll;
        tt = t[15:0]; ss = s[3:0]; ll = l[4:0];
        return {tt, ss, ll};
    endfunction

    function automatic string code_tag(input int c);
        case (c)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // one clock: drive, predict from pre-edge model state, update model, compare
    task automatic step(input bit rv, input int t, input int s, input int l, input bit rw,
                        input bit uv, input int uop, input int us, input int uw,
                        input int ut, input int ul, input int usl, input string rq);
        int e_oc, e_way, e_slot, e_act, mw, fw;
        string tg;
        req_valid = rv; req_line_addr = mkaddr(t, s, l); req_write = rw;
        upd_valid = uv; upd_op = uop[1:0]; upd_set = us[3:0]; upd_way = uw[1:0];
        upd_tag = ut[15:0]; upd_line = ul[4:0]; upd_slot = usl[3:0];
        e_oc = 0; e_way = 0; e_slot = 0; e_act = 0;
        if (rv) begin
            mw = -1; fw = -1;
            for (int w = 3; w >= 0; w--) begin
                if (m_valid[s][w] && m_tag[s][w] == t) mw = w;
                if (!m_valid[s][w]) fw = w;
            end
            if (mw >= 0) begin
                e_way = mw;
                if (!m_pres[s][mw][l] && !m_buf[s][mw]) begin e_oc = 3; e_act = 'b0111; end
                else if (m_pres[s][mw][l] && !m_buf[s][mw]) begin e_oc = 4; e_act = 'b0110; end
                else if (!m_pres[s][mw][l]) begin e_oc = 5; e_act = 'b0001; e_slot = m_slot[s][mw]; end
                else begin e_oc = 6; e_act = 0; e_slot = m_slot[s][mw]; end
                model_touch(s, mw);
            end else if (fw >= 0) begin
                e_oc = 1; e_way = fw; e_act = 'b1101;
            end else begin
                e_oc = 2; e_way = m_ord[s][3]; e_act = 'b1101;
            end
        end
        if (uv) begin
            case (uop)
                0: m_pres[us][uw][ul] = 1;
                1: begin
                    m_valid[us][uw] = 1; m_tag[us][uw] = ut; m_buf[us][uw] = 1; m_slot[us][uw] = usl;
                    for (int i = 0; i < 32; i++) m_pres[us][uw][i] = (i == ul);
                    model_touch(us, uw);
                end
                2: begin m_buf[us][uw] = 1; m_slot[us][uw] = usl; end
                default: m_buf[us][uw] = 0;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; upd_valid = 0;
        tg = (rq == "") ? code_tag(e_oc) : rq;
        check(rsp_valid == rv, "R2", "rsp_valid", int'(rsp_valid), int'(rv));
        if (rv) begin
            check(rsp_outcome == e_oc[2:0], tg, "outcome", int'(rsp_outcome), e_oc);
            check(rsp_way == e_way[1:0], tg, "way", int'(rsp_way), e_way);
            check(rsp_slot == e_slot[3:0], tg, "slot", int'(rsp_slot), e_slot);
            check(rsp_action == e_act[3:0], tg, "action", int'(rsp_action), e_act);
            check(rsp_write == rw, "R11", "write echo", int'(rsp_write), int'(rw));
        end
    endtask

    task automatic lookup(input int t, input int s, input int l, input bit rw, input string rq);
        step(1, t, s, l, rw, 0, 0, 0, 0, 0, 0, 0, rq);
    endtask

    task automatic upd(input int op, input int s, input int w, input int t, input int l,
                       input int sl, input string rq);
        step(0, 0, 0, 0, 0, 1, op, s, w, t, l, sl, rq);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle response after reset
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        // R1: first lookup is a free-way page miss on way 0
        lookup('h0724, 3, 0, 0, "R1");
        check(rsp_outcome == 3'd1 && rsp_way == 2'd0, "R1", "first miss", int'(rsp_outcome), 1);

        // worked entry: tag 0x0724, lines 0 and 1 present, buffered, slot 0xB
        upd(1, 3, 0, 'h0724, 0, 'hB, "R9");
        upd(0, 3, 0, 0, 1, 0, "R9");
        lookup('h0724, 3, 1, 0, "R8");
        check(rsp_slot == 4'hB, "R8", "worked entry slot", int'(rsp_slot), 'hB);
        lookup('h0724, 3, 0, 1, "R8");
        lookup('h0724, 3, 2, 0, "R7");
        upd(3, 3, 0, 0, 0, 0, "R9");
        lookup('h0724, 3, 0, 0, "R6");
        lookup('h0724, 3, 7, 1, "R5");
        upd(2, 3, 0, 0, 0, 5, "R9");
        lookup('h0724, 3, 0, 0, "R8");
        // same-cycle lookup and fill: old state answers, then the fill is seen
        step(1, 'h0724, 3, 9, 0, 1, 0, 3, 0, 0, 9, 0, "R2");
        lookup('h0724, 3, 9, 0, "R9");

        // fill remaining ways, then drive the victim choice
        upd(1, 3, 1, 'h0100, 4, 1, "R9");
        lookup('h0300, 3, 0, 0, "R3");
        upd(1, 3, 2, 'h0200, 4, 2, "R9");
        upd(1, 3, 3, 'h0300, 4, 3, "R9");
        lookup('h0999, 3, 0, 0, "R4");
        lookup('h0724, 3, 0, 0, "R10");
        lookup('h0999, 3, 0, 1, "R4");
        lookup('h0100, 3, 4, 0, "R10");
        lookup('h0999, 3, 0, 0, "R10");
        // same-cycle hit and install in one set: install counts as newer
        step(1, 'h0200, 3, 4, 0, 1, 1, 3, 3, 'h0400, 2, 6, "R10");
        lookup('h0999, 3, 0, 0, "R10");

        // random mix over two sets and six tags
        for (int i = 0; i < 1500; i++) begin
            int rs, rt, rl, us, uw, ut, uop;
            bit rv, uv, rw;
            rv = ($urandom % 4) != 0;
            rs = $urandom % 2; rt = 'h10 + ($urandom % 6); rl = $urandom % 4;
            rw = $urandom % 2;
            uv = ($urandom % 2) != 0;
            uop = $urandom % 4; us = $urandom % 2; uw = $urandom % 4;
            ut = 'h10 + ($urandom % 6);
            if (uop == 1) begin
                for (int w = 0; w < 4; w++)
                    if (w != uw && m_valid[us][w] && m_tag[us][w] == ut) uop = 0;
            end
            step(rv, rt, rs, rl, rw, uv, uop, us, uw, ut, $urandom % 4, $urandom % 16, "");
        end
        finish_run();
    end
endmodule